// File: doc/BRIEF.md
# Multicore Diagnosis Phase Sequencer

This block steers the diagnosis of a suspected permanent hardware fault on a small multicore processor once a software-level symptom has been raised. When a symptom arrives it orders a rollback of all cores and watches the re-execution. If the symptom does not come back, the event counts as transient and diagnosis ends. If it does come back, the block starts a load-logging pass. That pass is followed by a triple-redundant replay pass. In the replay pass, every core's logged thread is re-run in turn on a group of three cores while external comparison logic watches for disagreement.

The logging and replay passes repeat over short traces. A pass of logging ends when the log buffer is full, when a symptom appears, or when the retired-instruction count reaches a programmable threshold. At that point processor state is checkpointed and the replay steps begin. The first divergence names the faulty core. A replay pass with no divergence starts a fresh iteration with a cleared log. If a termination condition was hit in the preceding logging pass, the block instead reports a non-deterministic software bug. A cross-call interrupt that lands during a replay step restarts that step.

Top module: `diag_seq_top`

## Requirements
- R1: The phase output uses idle=0, replay=1, logging=2, replay-vote=3 and done=4. In idle, a symptom moves the phase to replay and pulses the rollback strobe for one cycle.
- R2: In replay, a symptom moves to logging and pulses both rollback and log-clear. A completed re-execution with no symptom ends diagnosis with done high and verdict 0 (none).
- R3: In logging, any of log-full, a symptom, or an instruction count at or above the threshold pulses the checkpoint strobe, enters replay-vote and issues a step start for thread 0.
- R4: In replay-vote step k the thread select equals k, and the group mask (bit j = core j) holds exactly three cores. With four cores, threads 0 to 2 use mask 0111 and thread 3 uses mask 1011.
- R5: A step completion without divergence advances to the next thread and pulses step start.
- R6: A divergence in replay-vote ends diagnosis with done high, verdict 1 (core) and the diverging core's ID on the fault-core output. It wins over a simultaneous interrupt or step completion.
- R7: A cross-call interrupt during a replay-vote step re-issues step start for the same thread. It wins over a simultaneous step completion.
- R8: Completing the last step with no divergence and no termination condition returns to logging. It pulses log-clear, resets the thread to 0 and increments the iteration count, which saturates.
- R9: Completing the last step with no divergence ends diagnosis with verdict 2 (software bug) when the preceding logging pass ended on the threshold or on a symptom.
- R10: Done, verdict and fault core hold until a new symptom. That symptom starts a new diagnosis and clears done, verdict, fault core, thread and iteration count.
- R11: After reset the phase is idle, all strobes, done and verdict are 0, and the iteration count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| symptom_i | input | 1 | Symptom detector pulse |
| log_full_i | input | 1 | Load-log buffer full |
| step_done_i | input | 1 | Current re-execution or replay step finished |
| diverge_i | input | 1 | Replay comparison found a mismatch |
| diverge_core_i | input | CID_W | Core that produced the mismatch |
| xcall_i | input | 1 | Unmaskable cross-call interrupt pulse |
| insn_cnt_i | input | CNT_W | Instructions retired in the current logging pass |
| threshold_i | input | CNT_W | Logging instruction threshold |
| rollback_o | output | 1 | Roll all cores back to checkpoint |
| ckpt_o | output | 1 | Take processor and TLB checkpoint |
| log_clear_o | output | 1 | Clear the load logs |
| step_go_o | output | 1 | Start (or restart) a replay step |
| phase_o | output | 3 | Current phase |
| group_mask_o | output | N_CORES | Cores taking part in the current step |
| thread_sel_o | output | CID_W | Thread (core log and checkpoint) being replayed |
| iter_o | output | ITER_W | Completed logging/replay iterations |
| done_o | output | 1 | Verdict valid |
| verdict_o | output | 2 | 0 none, 1 faulty core, 2 software bug |
| fault_core_o | output | CID_W | Faulty core ID when verdict is 1 |

## Verification
Every result except the group mask appears one clock after the input that causes it. That covers the phase, the strobes, the thread select, done, the verdict and the fault core, because each is a register loaded on the edge that samples that input. The group mask is decoded from the registered thread index, so it appears in that same cycle. The bench applies each stimulus row on a falling edge, lets one rising edge pass, and compares all outputs on the following falling edge. A strobe is therefore seen exactly in its single high cycle and is confirmed low on the row after.

// File: rtl/diag_pkg.sv
package diag_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_REPLAY = 3'd1,
    PH_LOG    = 3'd2,
    PH_VOTE   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    VD_NONE  = 2'd0,
    VD_CORE  = 2'd1,
    VD_SWBUG = 2'd2
  } verdict_e;
endpackage

// File: rtl/diag_group_sel.sv
// Decodes the three-core group for a replay step. Full groups of three
// replay their own threads; leftover threads run on the leftover cores
// topped up with the lowest-numbered cores.
module diag_group_sel #(
  parameter int N_CORES = 4,
  parameter int CID_W   = 2
) (
  input  logic [CID_W-1:0]   step_i,
  output logic [N_CORES-1:0] mask_o
);
  localparam int GROUPS = N_CORES / 3;
  localparam int FULL   = 3 * GROUPS;
  localparam int LEFT   = N_CORES - FULL;
  localparam int FILL   = (LEFT == 0) ? 0 : 3 - LEFT;

  for (genvar j = 0; j < N_CORES; j++) begin : g_bit
    localparam int JG = j / 3;
    localparam bit J_IN_FULL = (j < FULL);
    localparam bit J_IN_LEFT = (j >= FULL) || (j < FILL);
    always_comb begin
      if (int'(step_i) < FULL)
        mask_o[j] = J_IN_FULL && (int'(step_i) / 3 == JG);
      else
        mask_o[j] = J_IN_LEFT;
    end
  end
endmodule

// File: rtl/diag_log_mon.sv
// Decides when a logging pass ends and whether that end is terminal.
module diag_log_mon #(
  parameter int CNT_W = 32
) (
  input  logic             log_full_i,
  input  logic             symptom_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             end_o,
  output logic             term_o
);
  logic thr_hit;
  assign thr_hit = (cnt_i >= thr_i);
  assign term_o  = symptom_i | thr_hit;
  assign end_o   = log_full_i | term_o;
endmodule

// File: rtl/diag_seq_top.sv
module diag_seq_top
  import diag_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int CNT_W   = 32,
  parameter int ITER_W  = 8,
  localparam int CID_W  = $clog2(N_CORES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               symptom_i,
  input  logic               log_full_i,
  input  logic               step_done_i,
  input  logic               diverge_i,
  input  logic [CID_W-1:0]   diverge_core_i,
  input  logic               xcall_i,
  input  logic [CNT_W-1:0]   insn_cnt_i,
  input  logic [CNT_W-1:0]   threshold_i,
  output logic               rollback_o,
  output logic               ckpt_o,
  output logic               log_clear_o,
  output logic               step_go_o,
  output logic [2:0]         phase_o,
  output logic [N_CORES-1:0] group_mask_o,
  output logic [CID_W-1:0]   thread_sel_o,
  output logic [ITER_W-1:0]  iter_o,
  output logic               done_o,
  output logic [1:0]         verdict_o,
  output logic [CID_W-1:0]   fault_core_o
);
  localparam logic [CID_W-1:0] LAST_STEP = CID_W'(N_CORES - 1);

  phase_e             state_q;
  verdict_e           verdict_q;
  logic [CID_W-1:0]   step_q, fcore_q;
  logic [ITER_W-1:0]  iter_q;
  logic               term_q, rollback_q, ckpt_q, clear_q, go_q, done_q;
  logic               log_end, log_term;
  logic [N_CORES-1:0] mask;

  diag_log_mon #(.CNT_W(CNT_W)) log_mon_i (
    .log_full_i (log_full_i),
    .symptom_i  (symptom_i),
    .cnt_i      (insn_cnt_i),
    .thr_i      (threshold_i),
    .end_o      (log_end),
    .term_o     (log_term)
  );

  diag_group_sel #(.N_CORES(N_CORES), .CID_W(CID_W)) group_sel_i (
    .step_i (step_q),
    .mask_o (mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PH_IDLE;
      verdict_q  <= VD_NONE;
      step_q     <= '0;
      fcore_q    <= '0;
      iter_q     <= '0;
      term_q     <= 1'b0;
      rollback_q <= 1'b0;
      ckpt_q     <= 1'b0;
      clear_q    <= 1'b0;
      go_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      rollback_q <= 1'b0;
      ckpt_q     <= 1'b0;
      clear_q    <= 1'b0;
      go_q       <= 1'b0;
      case (state_q)
        PH_IDLE, PH_DONE: begin
          if (symptom_i) begin
            state_q    <= PH_REPLAY;
            rollback_q <= 1'b1;
            done_q     <= 1'b0;
            verdict_q  <= VD_NONE;
            fcore_q    <= '0;
            iter_q     <= '0;
            step_q     <= '0;
            term_q     <= 1'b0;
          end
        end
        PH_REPLAY: begin
          if (symptom_i) begin
            state_q    <= PH_LOG;
            rollback_q <= 1'b1;
            clear_q    <= 1'b1;
          end else if (step_done_i) begin
            state_q   <= PH_DONE;
            done_q    <= 1'b1;
            verdict_q <= VD_NONE;
          end
        end
        PH_LOG: begin
          if (log_end) begin
            state_q <= PH_VOTE;
            ckpt_q  <= 1'b1;
            go_q    <= 1'b1;
            step_q  <= '0;
            term_q  <= log_term;
          end
        end
        PH_VOTE: begin
          if (diverge_i) begin
            state_q   <= PH_DONE;
            done_q    <= 1'b1;
            verdict_q <= VD_CORE;
            fcore_q   <= diverge_core_i;
          end else if (xcall_i) begin
            go_q <= 1'b1;
          end else if (step_done_i) begin
            if (step_q == LAST_STEP) begin
              if (term_q) begin
                state_q   <= PH_DONE;
                done_q    <= 1'b1;
                verdict_q <= VD_SWBUG;
              end else begin
                state_q <= PH_LOG;
                clear_q <= 1'b1;
                step_q  <= '0;
                if (iter_q != '1) iter_q <= iter_q + 1'b1;
              end
            end else begin
              step_q <= step_q + 1'b1;
              go_q   <= 1'b1;
            end
          end
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign rollback_o   = rollback_q;
  assign ckpt_o       = ckpt_q;
  assign log_clear_o  = clear_q;
  assign step_go_o    = go_q;
  assign phase_o      = state_q;
  assign group_mask_o = mask;
  assign thread_sel_o = step_q;
  assign iter_o       = iter_q;
  assign done_o       = done_q;
  assign verdict_o    = verdict_q;
  assign fault_core_o = fcore_q;

  // R1: a symptom in idle opens the replay phase with a rollback
  p_idle_symptom_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_IDLE && symptom_i) |=> (rollback_q && state_q == PH_REPLAY));

  // R3: a checkpoint always coincides with the first vote step
  p_ckpt_vote_r3: assert property (@(posedge clk) disable iff (rst)
    ckpt_q |-> (state_q == PH_VOTE && go_q && step_q == '0));

  // R4: each vote step runs on exactly three cores
  p_three_cores_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_VOTE) |-> ($countones(group_mask_o) == 3));

  // R6: divergence reports the diverging core
  p_diverge_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_VOTE && diverge_i) |=>
      (done_q && verdict_q == VD_CORE && fcore_q == $past(diverge_core_i)));

  // R7: an interrupt restarts the same step
  p_xcall_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_VOTE && xcall_i && !diverge_i) |=>
      (go_q && step_q == $past(step_q) && state_q == PH_VOTE));

  // R8: a new iteration increments the counter unless saturated
  p_iter_step_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_LOG && $past(state_q) == PH_VOTE) |->
      (iter_q == $past(iter_q) + 1'b1 || $past(iter_q) == '1));
endmodule

// File: tb/diag_seq_top_tb.sv
`timescale 1ns/1ps
module diag_seq_top_tb_top;
  localparam int N   = 4;
  localparam int CW  = 2;
  localparam int TW  = 32;
  localparam int IW  = 8;
  localparam int THR = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym, full, sdone, div, xc;
  logic [CW-1:0] dcore;
  logic [TW-1:0] cnt;
  logic rb, ck, clr, go, dn;
  logic [2:0] ph;
  logic [N-1:0] mask;
  logic [CW-1:0] th, fc;
  logic [IW-1:0] iter;
  logic [1:0] vd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  diag_seq_top #(.N_CORES(N), .CNT_W(TW), .ITER_W(IW)) dut_i (
    .clk(clk), .rst(rst), .symptom_i(sym), .log_full_i(full),
    .step_done_i(sdone), .diverge_i(div), .diverge_core_i(dcore),
    .xcall_i(xc), .insn_cnt_i(cnt), .threshold_i(TW'(THR)),
    .rollback_o(rb), .ckpt_o(ck), .log_clear_o(clr), .step_go_o(go),
    .phase_o(ph), .group_mask_o(mask), .thread_sel_o(th), .iter_o(iter),
    .done_o(dn), .verdict_o(vd), .fault_core_o(fc)
  );

  typedef struct packed {
    logic s, f, d, v, x, t;
    logic [1:0] c;
    logic [2:0] ph;
    logic rb, ck, cl, go;
    logic [1:0] th;
    logic dn;
    logic [1:0] vd, fc;
  } row_t;

  // inputs: sym full sdone div xcall thr dcore | expected outputs
  localparam row_t TBL [24] = '{
    '{1,0,0,0,0,0,0, 1,1,0,0,0,0,0,0,0}, // R1
    '{0,0,0,0,0,0,0, 1,0,0,0,0,0,0,0,0}, // R1 strobe drops
    '{1,0,0,0,0,0,0, 2,1,0,1,0,0,0,0,0}, // R2
    '{0,0,0,0,0,0,0, 2,0,0,0,0,0,0,0,0}, // R3 below threshold
    '{0,1,0,0,0,0,0, 3,0,1,0,1,0,0,0,0}, // R3 log full
    '{0,0,0,0,0,0,0, 3,0,0,0,0,0,0,0,0}, // R5 waits
    '{0,0,1,0,0,0,0, 3,0,0,0,1,1,0,0,0}, // R5
    '{0,0,0,0,1,0,0, 3,0,0,0,1,1,0,0,0}, // R7
    '{0,0,1,0,1,0,0, 3,0,0,0,1,1,0,0,0}, // R7 priority
    '{0,0,1,0,0,0,0, 3,0,0,0,1,2,0,0,0}, // R5
    '{0,0,1,0,0,0,0, 3,0,0,0,1,3,0,0,0}, // R4 leftover step
    '{0,0,1,0,0,0,0, 2,0,0,1,0,0,0,0,0}, // R8
    '{0,0,0,0,0,1,0, 3,0,1,0,1,0,0,0,0}, // R3 threshold
    '{0,0,1,0,0,0,0, 3,0,0,0,1,1,0,0,0},
    '{0,0,1,0,0,0,0, 3,0,0,0,1,2,0,0,0},
    '{0,0,1,0,0,0,0, 3,0,0,0,1,3,0,0,0},
    '{0,0,1,0,0,0,0, 4,0,0,0,0,3,1,2,0}, // R9
    '{0,0,0,0,0,0,0, 4,0,0,0,0,3,1,2,0}, // R10 hold
    '{1,0,0,0,0,0,0, 1,1,0,0,0,0,0,0,0}, // R10 restart
    '{0,0,1,0,0,0,0, 4,0,0,0,0,0,1,0,0}, // R2 transient
    '{1,0,0,0,0,0,0, 1,1,0,0,0,0,0,0,0},
    '{1,0,0,0,0,0,0, 2,1,0,1,0,0,0,0,0},
    '{1,0,0,0,0,0,0, 3,0,1,0,1,0,0,0,0}, // R3 symptom
    '{0,0,1,1,0,0,2, 4,0,0,0,0,0,1,1,2}  // R6
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic s, f, d, v, x, t, input logic [1:0] c);
    sym = s; full = f; sdone = d; div = v; xc = x; dcore = c;
    cnt = t ? TW'(THR) : TW'(5);
  endtask

  task automatic step_clk();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    drive(0,0,0,0,0,0,0);
    rst = 1'b1;
    step_clk();
    step_clk();
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(0,0,0,0,0,0,0);
    @(negedge clk);
    do_reset();
    // R11 reset state
    check("R11", "phase", ph, 0);
    check("R11", "strobes", {rb, ck, clr, go, dn}, 0);
    check("R11", "verdict", vd, 0);
    check("R11", "iter", iter, 0);

    for (int i = 0; i < 24; i++) begin
      drive(TBL[i].s, TBL[i].f, TBL[i].d, TBL[i].v, TBL[i].x, TBL[i].t, TBL[i].c);
      step_clk();
      check("R1-R10 row", "phase", ph, TBL[i].ph);
      check("R1-R10 row", "strobes rb/ck/clr/go", {rb, ck, clr, go},
            {TBL[i].rb, TBL[i].ck, TBL[i].cl, TBL[i].go});
      check("R4", "thread", th, TBL[i].th);
      check("R10", "done/verdict/core", {dn, vd, fc}, {TBL[i].dn, TBL[i].vd, TBL[i].fc});
      if (ph == 3) check("R4", "group mask", mask, (th < 3) ? 4'b0111 : 4'b1011);
    end

    // R8: iteration count across two clean passes
    do_reset();
    drive(1,0,0,0,0,0,0); step_clk(); step_clk();
    for (int p = 1; p <= 2; p++) begin
      drive(0,1,0,0,0,0,0); step_clk();
      for (int k = 0; k < N; k++) begin drive(0,0,1,0,0,0,0); step_clk(); end
      check("R8", "iter", iter, p);
      check("R8", "phase", ph, 2);
    end

    // R6: divergence beats interrupt and step completion
    drive(0,1,0,0,0,0,0); step_clk();
    drive(0,0,1,1,1,0,3); step_clk();
    check("R6", "phase", ph, 4);
    check("R6", "verdict", vd, 1);
    check("R6", "fault core", fc, 3);
    drive(0,0,0,0,0,0,0); step_clk();
    check("R10", "fault core held", fc, 3);

    // R3: count above threshold also ends logging; R9 follows
    drive(1,0,0,0,0,0,0); step_clk(); step_clk();
    drive(0,0,0,0,0,0,0); cnt = TW'(THR + 50); step_clk();
    check("R3", "phase", ph, 3);
    for (int k = 0; k < N; k++) begin drive(0,0,1,0,0,0,0); step_clk(); end
    check("R9", "verdict", vd, 2);
    check("R9", "done", dn, 1);

    drive(0,0,0,0,0,0,0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule